// File: doc/BRIEF.md
# SHA-512 Message Schedule Generator

This block expands one 1024-bit SHA-512 message block into the 80 schedule words that the compression rounds use, one 64-bit word per clock. The message arrives as sixteen 64-bit words on a streaming input with a ready/valid handshake. It is held in a sliding window of sixteen 64-bit stages. A single 2:1 multiplexer feeds the window. While the block is loading, the multiplexer passes the streamed word. For the remaining 64 rounds it passes a feedback word computed from earlier window entries.

On every clock that produces a word, the block raises `w_valid` and presents the word together with its round index. A word is therefore available in the same cycle as the round it belongs to. When the schedule reaches round 79, a one-cycle `done` pulse is raised. The very next cycle is round 0 of the following block, so back-to-back blocks run with no idle cycle. A `start` pulse abandons whatever is in progress and returns the block to round 0.

Top module: `wsched_gen`

## Requirements
- R1: After reset, `w_round` is 0, `in_ready` is 1, and `done` is 0. While `in_valid` is low, `w_valid` is also 0.
- R2: In rounds 0 to 15, `in_ready` is 1. A cycle with `in_valid` high emits `w_valid`=1 and `w_word`=`in_word` in that same cycle, and the word counts as message word number `w_round`.
- R3: In rounds 0 to 15, a cycle with `in_valid` low emits nothing (`w_valid`=0), and `w_round` keeps its value.
- R4: In rounds 16 to 79, `in_ready` is 0 and a word is emitted on every clock. `in_valid` and `in_word` have no effect on the emitted word. The word is W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16], with the sums taken modulo 2^64.
- R5: Here s0(x) = rotr(x,1) ^ rotr(x,8) ^ (x >> 7) and s1(x) = rotr(x,19) ^ rotr(x,61) ^ (x >> 6), where rotr is a right rotation of the 64-bit word.
- R6: `done` is 1 exactly in the cycle that emits the word for round 79, and is 0 in every other cycle.
- R7: The cycle after round 79 is round 0 of the next block, and `in_ready` is 1 in that cycle.
- R8: A cycle with `start` high emits nothing and forces `in_ready` to 0. The following cycle has `w_round`=0, whether the block was loading or computing. Words received before `start` have no effect on the new block's schedule.
- R9: `w_round` stays within 0 to 79. It rises by exactly one after each emitted word, except that it wraps from 79 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse; returns the schedule to round 0 |
| in_valid | input | 1 | Streamed message word is present |
| in_ready | output | 1 | Block accepts a message word this cycle |
| in_word | input | 64 | Streamed message word |
| w_valid | output | 1 | A schedule word is emitted this cycle |
| w_word | output | 64 | Schedule word for round `w_round` |
| w_round | output | 7 | Round index of the emitted word |
| done | output | 1 | Pulse with the round-79 word |

## Verification
The bench goes after the seam between the loading phase and the feedback phase. A design that switches the multiplexer one cycle early or late produces a wrong word 15 or 16. A design with a misplaced tap or a wrong rotation amount diverges from the first computed word. Stall cycles are inserted at the first, a middle, and the last message word: a design that advances on an idle cycle shifts the whole schedule by one. Blocks are run back to back with live, changing `in_valid` and `in_word` during the computed rounds, which exposes a missed wrap at round 79 or any leakage of the input into feedback words. `start` is applied once during loading and once during computing; a design that keeps the old round count, or reuses stale window contents, mismatches the fresh block.

// File: rtl/sched512_pkg.sv
package sched512_pkg;

  typedef logic [63:0] word_t;

  // rotate a 64-bit word right by a constant amount
  function automatic word_t ror64(input word_t x, input int unsigned n);
    return (x >> n) | (x << (64 - n));
  endfunction

  // small sigma 0: used on the oldest-but-one tap (R5)
  function automatic word_t ssig0(input word_t x);
    return ror64(x, 1) ^ ror64(x, 8) ^ (x >> 7);
  endfunction

  // small sigma 1: used on the second newest tap (R5)
  function automatic word_t ssig1(input word_t x);
    return ror64(x, 19) ^ ror64(x, 61) ^ (x >> 6);
  endfunction

  // full feedback word, modulo 2^64 (R4)
  function automatic word_t sched_mix(input word_t w_t2, input word_t w_t7,
                                      input word_t w_t15, input word_t w_t16);
    return ssig1(w_t2) + w_t7 + ssig0(w_t15) + w_t16;
  endfunction

endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl #(
  parameter int ROUNDS = 80,
  parameter int LOAD   = 16,
  parameter int RND_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  output logic [RND_W-1:0] rnd,
  output logic             load_phase,
  output logic             fire,
  output logic             last
);
  localparam logic [RND_W-1:0] LAST_R = RND_W'(ROUNDS - 1);
  localparam logic [RND_W-1:0] LOAD_R = RND_W'(LOAD);

  assign load_phase = (rnd < LOAD_R);
  assign last       = (rnd == LAST_R);
  // a word is produced when not restarting and either input data or feedback is there
  assign fire       = !start && (load_phase ? in_valid : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rnd <= '0;
    else if (start)  rnd <= '0;
    else if (fire)   rnd <= last ? '0 : rnd + 1'b1;
  end
endmodule

// File: rtl/sched_window.sv
module sched_window
  import sched512_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift_en,
  input  logic  sel_ext,
  input  word_t ext_word,
  input  word_t fb_word,
  output word_t head_word,
  output word_t tap_t2,
  output word_t tap_t7,
  output word_t tap_t15,
  output word_t tap_t16
);
  // stage k holds W[t-1-k]
  localparam int I_T2  = 1;
  localparam int I_T7  = 6;
  localparam int I_T15 = DEPTH - 2;
  localparam int I_T16 = DEPTH - 1;

  assign head_word = sel_ext ? ext_word : fb_word;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stg
    word_t q;
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= head_word;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= g_stg[k-1].q;
      end
    end
  end

  assign tap_t2  = g_stg[I_T2].q;
  assign tap_t7  = g_stg[I_T7].q;
  assign tap_t15 = g_stg[I_T15].q;
  assign tap_t16 = g_stg[I_T16].q;
endmodule

// File: rtl/sched_feedback.sv
module sched_feedback
  import sched512_pkg::*;
(
  input  word_t w_t2,
  input  word_t w_t7,
  input  word_t w_t15,
  input  word_t w_t16,
  output word_t fb_word
);
  assign fb_word = sched_mix(w_t2, w_t7, w_t15, w_t16);
endmodule

// File: rtl/wsched_gen.sv
module wsched_gen
  import sched512_pkg::*;
#(
  parameter int ROUNDS = 80,
  parameter int LOAD   = 16,
  parameter int RND_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_word,
  output logic             w_valid,
  output logic [63:0]      w_word,
  output logic [RND_W-1:0] w_round,
  output logic             done
);
  logic  load_phase, fire, last;
  word_t t2, t7, t15, t16, fb, head;

  sched_ctrl #(.ROUNDS(ROUNDS), .LOAD(LOAD), .RND_W(RND_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .rnd(w_round), .load_phase(load_phase), .fire(fire), .last(last)
  );

  sched_window #(.DEPTH(LOAD)) u_win (
    .clk(clk), .rst_n(rst_n), .shift_en(fire), .sel_ext(load_phase),
    .ext_word(in_word), .fb_word(fb), .head_word(head),
    .tap_t2(t2), .tap_t7(t7), .tap_t15(t15), .tap_t16(t16)
  );

  sched_feedback u_fb (
    .w_t2(t2), .w_t7(t7), .w_t15(t15), .w_t16(t16), .fb_word(fb)
  );

  assign in_ready = load_phase && !start;
  assign w_valid  = fire;
  assign w_word   = head;
  assign done     = fire && last;
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int ROUNDS = 80,
  parameter int LOAD   = 16,
  parameter int RND_W  = $clog2(ROUNDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             w_valid,
  input logic [RND_W-1:0] w_round,
  input logic             done
);
  localparam logic [RND_W-1:0] LAST_R = RND_W'(ROUNDS - 1);
  localparam logic [RND_W-1:0] LOAD_R = RND_W'(LOAD);

  a_r9_round_range: assert property (@(posedge clk) disable iff (!rst_n)
    w_round <= LAST_R);

  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_round != LAST_R) |=> (w_round == $past(w_round) + 1'b1));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_round == LAST_R) |=> (w_round == '0));

  a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (w_valid && w_round == LAST_R));

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> w_valid);

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_valid && !start) |=> $stable(w_round));

  a_r4_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (w_round >= LOAD_R) |-> !in_ready);

  a_r8_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!w_valid && !in_ready));

  a_r8_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (w_round == '0));
endmodule

bind wsched_gen wsched_chk #(.ROUNDS(ROUNDS), .LOAD(LOAD), .RND_W(RND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
  .in_ready(in_ready), .w_valid(w_valid), .w_round(w_round), .done(done)
);

// File: tb/wsched_gen_bench.sv
`timescale 1ns/1ps
module wsched_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic        in_ready, w_valid, done;
  logic [63:0] w_word;
  logic [6:0]  w_round;

  int nchecks = 0;
  int nfail = 0;
  logic [70:0] sbq[$];
  logic [63:0] junk = 64'h0123_4567_89ab_cdef;

  always #2 clk = ~clk;

  wsched_gen u_wsched_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .w_valid(w_valid),
    .w_word(w_word), .w_round(w_round), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side restatement of the sigma functions (R5)
  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction
  function automatic logic [63:0] bs0(input logic [63:0] x);
    return rr(x, 1) ^ rr(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [63:0] bs1(input logic [63:0] x);
    return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
  endfunction

  // monitor: pop scoreboard on every emitted word
  always @(negedge clk) begin
    if (rst_n) begin
      if (w_valid) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R2 unexpected word", {57'b0, w_round}, 64'd0);
        end else begin
          logic [70:0] it;
          it = sbq.pop_front();
          chk(w_round == it[70:64], "R9 round index", {57'b0, w_round}, {57'b0, it[70:64]});
          chk(w_word == it[63:0], (it[70:64] < 7'd16) ? "R2 message word" : "R4 feedback word",
              w_word, it[63:0]);
          chk(done == (it[70:64] == 7'd79), "R6 done with round 79", {63'b0, done},
              {63'b0, (it[70:64] == 7'd79)});
        end
      end else begin
        chk(done == 1'b0, "R6 done without word", {63'b0, done}, 64'd0);
      end
    end
  end

  // drive one block; abort_at < 80 applies start at that round instead
  task automatic feed(input logic [63:0] m[16], input logic [15:0] gaps,
                      input int abort_at, input bit chk_wrap);
    logic [63:0] ew[80];
    for (int t = 0; t < 80; t++) begin
      if (t < 16) ew[t] = m[t];
      else ew[t] = bs1(ew[t-2]) + ew[t-7] + bs0(ew[t-15]) + ew[t-16];
      sbq.push_back({7'(t), ew[t]});
    end
    for (int r = 0; r < 80; r++) begin
      if (r == abort_at) begin
        start = 1'b1; in_valid = 1'b1; in_word = junk;
        @(negedge clk);
        chk(!w_valid && !in_ready, "R8 start cycle quiet", {62'b0, w_valid, in_ready}, 64'd0);
        sbq.delete();
        @(posedge clk); #1;
        start = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk(w_round == 7'd0, "R8 round after start", {57'b0, w_round}, 64'd0);
        @(posedge clk); #1;
        return;
      end
      if (r < 16 && gaps[r]) begin
        in_valid = 1'b0; in_word = junk;
        @(negedge clk);
        chk(!w_valid && in_ready, "R3 stall emits nothing", {62'b0, w_valid, in_ready}, 64'd1);
        chk(w_round == 7'(r), "R3 round held", {57'b0, w_round}, 64'(r));
        @(posedge clk); #1;
      end
      if (r < 16) begin
        in_valid = 1'b1; in_word = m[r];
        @(negedge clk);
        chk(in_ready, "R2 ready while loading", {63'b0, in_ready}, 64'd1);
        if (r == 0 && chk_wrap)
          chk(w_round == 7'd0, "R7 next block at round 0", {57'b0, w_round}, 64'd0);
      end else begin
        junk = {junk[62:0], junk[63] ^ junk[60]};
        in_valid = junk[0]; in_word = junk;
        @(negedge clk);
        chk(!in_ready, "R4 not ready while computing", {63'b0, in_ready}, 64'd0);
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchecks++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    logic [63:0] ma[16], mz[16], mo[16], mc[16];
    logic [63:0] s;
    s = 64'h9e37_79b9_7f4a_7c15;
    for (int i = 0; i < 16; i++) begin
      s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
      ma[i] = s;
      mz[i] = '0;
      mo[i] = '1;
      mc[i] = {32'(i), ~32'(i * 7)};
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(w_round == 7'd0, "R1 reset round", {57'b0, w_round}, 64'd0);
    chk(in_ready && !w_valid && !done, "R1 reset flags",
        {61'b0, in_ready, w_valid, done}, 64'd4);
    @(posedge clk); #1;

    feed(ma, 16'h0000, 80, 1'b0);  // plain block
    feed(mo, 16'h0000, 80, 1'b1);  // back to back, all ones
    feed(mz, 16'h0000, 80, 1'b1);  // back to back, all zeros
    feed(mc, 16'h8009, 80, 1'b1);  // stalls at words 0, 3 and 15
    feed(mo, 16'h0000, 5, 1'b1);   // restart during loading
    feed(ma, 16'h0000, 80, 1'b0);
    feed(mc, 16'h0010, 30, 1'b1);  // restart during computing
    feed(mo, 16'h0400, 80, 1'b0);

    repeat (2) @(posedge clk);
    chk(sbq.size() == 0, "R9 all words emitted", 64'(sbq.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule